// File: doc/BRIEF.md
# Set/Clear-Enable Interrupt Controller

This block gathers sixteen interrupt request lines, gates them with a per-source enable mask and drives one combined interrupt line to the processor. Software reaches it through a small 32-bit register bus. Reading the status register returns the requests that are both raised and enabled. The mask is changed only by writing ones to a "set" location or to a "clear" location. Because of this, no handler ever needs a read-modify-write sequence on the mask. The enable mask itself is read back at the set location.

Alongside the combined line, the block also reports a vector number. This is the index of the lowest-numbered pending source in the range 1 to 15. Source 1 wins over all the others. Source 0 can be enabled and is visible in the status register, but it never raises the combined line and is never reported as the vector. When nothing in 1 to 15 is pending, the vector carries an all-ones "none" code.

A parameter selects whether the raw request lines are registered once on entry or used directly. The combined line, the vector and the read data are all registered outputs.

Top module: `setclr_irq_ctrl`

## Requirements
- R1: After a synchronous reset the enable mask is all zeros, the status register reads zero, `irq_out` is 0 and `irq_vec` is 5'h1F.
- R2: A read at offset 0x0 returns the raw requests ANDed with the enable mask in bits 15:0, with zeros above. A write to offset 0x0 changes neither the mask nor the status.
- R3: A write to offset 0x8 sets each enable bit whose data bit (15:0) is 1 and leaves the other enable bits unchanged. Data bits 31:16 are ignored. A read at offset 0x8 returns the mask in bits 15:0.
- R4: A write to offset 0xC clears each enable bit whose data bit (15:0) is 1, and data bits that are 0 leave the mask unchanged. Writing 0xFFFF there disables every source.
- R5: `irq_out` is 1 exactly when some source among 1 to 15 is both raised and enabled. Source 0 never raises it. With input registering on, a change on `irq_raw` shows on `irq_out`, `irq_vec` and status reads two clock edges later.
- R6: `irq_vec` is the lowest index in 1..15 whose masked status bit is set. If there is none, it is 5'h1F. It is 5'h1F whenever `irq_out` is 0.
- R7: Reads at offsets 0x4 and 0xC, which hold nothing readable, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 16 | Raw request lines, bit n is source n |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered from the address of the previous cycle |
| irq_out | output | 1 | Combined interrupt to the processor, registered |
| irq_vec | output | 5 | Lowest pending source 1..15, or 5'h1F for none, registered |

## Verification
The assertions assume that a write presents one word-aligned offset and that a write strobe lasts a single cycle. With this assumption, a set and a clear can never fall in the same cycle, and a cycle without a write to 0x8 or 0xC leaves the mask stable. The bench drives every input at the falling edge and pulses `reg_we` for one cycle per write. It holds `irq_raw` steady for several cycles before it samples the status, the vector or the combined line, so the two-edge input path has settled before any comparison.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets within the register window
  localparam int OFS_STATUS = 0;
  localparam int OFS_ENSET  = 8;
  localparam int OFS_ENCLR  = 12;
endpackage

// File: rtl/irqc_req_stage.sv
module irqc_req_stage #(
  parameter int NUM_SRC      = 16,
  parameter bit LATCH_INPUTS = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw_in,
  output logic [NUM_SRC-1:0] req_out
);
  generate
    if (LATCH_INPUTS) begin : g_latched
      logic [NUM_SRC-1:0] req_q;
      always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= raw_in;
      end
      assign req_out = req_q;
    end else begin : g_pass
      assign req_out = raw_in;
    end
  endgenerate
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_stb,
  input  logic               clr_stb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] mask
);
  logic [NUM_SRC-1:0] set_bits;
  logic [NUM_SRC-1:0] clr_bits;

  assign set_bits = set_stb ? wdata[NUM_SRC-1:0] : '0;
  assign clr_bits = clr_stb ? wdata[NUM_SRC-1:0] : '0;

  // clear dominates should both ever strike one bit together
  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= (mask | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 5
) (
  input  logic [NUM_SRC-1:0] status,
  output logic               hit,
  output logic [VEC_W-1:0]   vec
);
  localparam logic [VEC_W-1:0] NONE = {VEC_W{1'b1}};

  // scan downward so the lowest index from 1 up is the last to win
  always_comb begin
    hit = 1'b0;
    vec = NONE;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (status[i]) begin
        hit = 1'b1;
        vec = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/setclr_irq_ctrl.sv
module setclr_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC      = 16,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int VEC_W        = 5,
  parameter bit LATCH_INPUTS = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_raw,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_out,
  output logic [VEC_W-1:0]   irq_vec
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENSET  = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR  = ADDR_W'(OFS_ENCLR);
  localparam logic [VEC_W-1:0]  NONE     = {VEC_W{1'b1}};
  localparam int                PAD_W    = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] en_mask;
  logic [NUM_SRC-1:0] status;
  logic               set_stb;
  logic               clr_stb;
  logic               enc_hit;
  logic [VEC_W-1:0]   enc_vec;
  logic [DATA_W-1:0]  rd_next;

  irqc_req_stage #(.NUM_SRC(NUM_SRC), .LATCH_INPUTS(LATCH_INPUTS)) i_req (
    .clk(clk), .rst(rst), .raw_in(irq_raw), .req_out(req)
  );

  assign set_stb = reg_we && (reg_addr == A_ENSET);
  assign clr_stb = reg_we && (reg_addr == A_ENCLR);

  irqc_enable_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_en (
    .clk(clk), .rst(rst), .set_stb(set_stb), .clr_stb(clr_stb),
    .wdata(reg_wdata), .mask(en_mask)
  );

  assign status = req & en_mask;

  irqc_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) i_enc (
    .status(status), .hit(enc_hit), .vec(enc_vec)
  );

  always_comb begin
    case (reg_addr)
      A_STATUS: rd_next = {{PAD_W{1'b0}}, status};
      A_ENSET:  rd_next = {{PAD_W{1'b0}}, en_mask};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
      irq_vec   <= NONE;
    end else begin
      reg_rdata <= rd_next;
      irq_out   <= enc_hit;
      irq_vec   <= enc_vec;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int VEC_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_SRC-1:0] en_mask,
  input logic               irq_out,
  input logic [VEC_W-1:0]   irq_vec
);
  localparam logic [VEC_W-1:0]  NONE    = {VEC_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!irq_out && irq_vec == NONE && en_mask == '0));

  assert_set_takes_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_ENSET) |=>
      ((en_mask & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));

  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_ENCLR) |=>
      ((en_mask & $past(reg_wdata[NUM_SRC-1:0])) == '0));

  // R2: writes elsewhere, or no write, leave the mask alone
  assert_mask_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && (reg_addr == A_ENSET || reg_addr == A_ENCLR)) |=> $stable(en_mask));

  assert_irq_vec_agree_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out == (irq_vec != NONE));

  assert_vec_range_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_vec != NONE) |-> (irq_vec >= VEC_W'(1) && irq_vec < VEC_W'(NUM_SRC)));
endmodule

bind setclr_irq_ctrl irqc_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) i_irqc_checker (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .en_mask(en_mask), .irq_out(irq_out), .irq_vec(irq_vec)
);

// File: tb/test_setclr_irq_ctrl.sv
`timescale 1ns/1ps
module test_setclr_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_raw = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  logic [4:0]  irq_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  setclr_irq_ctrl i_setclr_irq_ctrl (
    .clk(clk), .rst(rst), .irq_raw(irq_raw), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .irq_vec(irq_vec)
  );

  // {raw[15:0], enable[15:0], expected vec[4:0], expected irq}
  localparam int NV = 10;
  localparam logic [37:0] VECS [NV] = '{
    {16'hFFFF, 16'hFFFF, 5'd1,  1'b1},
    {16'h0001, 16'hFFFF, 5'h1F, 1'b0},
    {16'h8000, 16'hFFFF, 5'd15, 1'b1},
    {16'hFFFF, 16'h0000, 5'h1F, 1'b0},
    {16'h0F00, 16'h0C00, 5'd10, 1'b1},
    {16'h00F0, 16'h0F0F, 5'h1F, 1'b0},
    {16'h1234, 16'hF0F0, 5'd4,  1'b1},
    {16'hA000, 16'hFFFF, 5'd13, 1'b1},
    {16'h0003, 16'h0002, 5'd1,  1'b1},
    {16'h0006, 16'h0006, 5'd1,  1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    check("R1 irq_vec", {27'd0, irq_vec}, 32'h1F);
    bus_read(4'h8, rd); check("R1 enable", rd, 32'd0);
    irq_raw = 16'hFFFF; settle();
    bus_read(4'h0, rd); check("R1 status", rd, 32'd0);
    check("R1 irq masked", {31'd0, irq_out}, 32'd0);

    // R5 R6 R2: vector table
    for (int k = 0; k < NV; k++) begin
      bus_write(4'hC, 32'h0000FFFF);
      bus_write(4'h8, {16'h0, VECS[k][21:6]});
      irq_raw = VECS[k][37:22];
      settle();
      check("R6 vec", {27'd0, irq_vec}, {27'd0, VECS[k][5:1]});
      check("R5 irq", {31'd0, irq_out}, {31'd0, VECS[k][0]});
      bus_read(4'h0, rd);
      check("R2 status", rd, {16'h0, VECS[k][37:22] & VECS[k][21:6]});
    end

    // R3 R4: incremental set and clear
    bus_write(4'hC, 32'h0000FFFF);
    bus_read(4'h8, rd); check("R4 clear all", rd, 32'd0);
    bus_write(4'h8, 32'h00000003);
    bus_write(4'h8, 32'h00000010);
    bus_read(4'h8, rd); check("R3 accumulate", rd, 32'h13);
    bus_write(4'hC, 32'h00000001);
    bus_read(4'h8, rd); check("R4 clear one", rd, 32'h12);
    bus_write(4'hC, 32'h00000000);
    bus_read(4'h8, rd); check("R4 zero no effect", rd, 32'h12);
    bus_write(4'h8, 32'hFFFF0000);
    bus_read(4'h8, rd); check("R3 upper ignored", rd, 32'h12);

    // R2: write to status offset ignored
    irq_raw = 16'h0016;
    bus_write(4'h0, 32'hFFFFFFFF);
    settle();
    bus_read(4'h8, rd); check("R2 write status mask", rd, 32'h12);
    bus_read(4'h0, rd); check("R2 write status value", rd, 32'h12);

    // R7: unreadable offsets
    bus_read(4'h4, rd); check("R7 offset 4", rd, 32'd0);
    bus_read(4'hC, rd); check("R7 offset C", rd, 32'd0);

    // R5: source 0 alone never raises irq
    bus_write(4'hC, 32'h0000FFFF);
    bus_write(4'h8, 32'h00000001);
    irq_raw = 16'h0001; settle();
    check("R5 src0 irq", {31'd0, irq_out}, 32'd0);
    check("R6 src0 vec", {27'd0, irq_vec}, 32'h1F);
    bus_read(4'h0, rd); check("R2 src0 status", rd, 32'h1);

    // R5: two-edge latency
    bus_write(4'h8, 32'h00000020);
    irq_raw = 16'h0000; settle();
    @(negedge clk) irq_raw = 16'h0020;
    @(negedge clk);
    check("R5 latency early", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R5 latency on", {31'd0, irq_out}, 32'd1);
    check("R6 latency vec", {27'd0, irq_vec}, 32'd5);

    // R1: reset mid-run clears mask
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 re-reset irq", {31'd0, irq_out}, 32'd0);
    bus_read(4'h8, rd); check("R1 re-reset mask", rd, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule